// File: doc/BRIEF.md
# Fast Ethernet PCS Receive Decoder

This block sits behind clock recovery and the descrambler in a 100 Mb/s twisted-pair receiver. It is clocked by the recovered bit clock and takes one descrambled, NRZI-decoded line bit per cycle. From that stream it produces the nibble-wide receive side of the media independent interface. While the line is idle it hunts for the start of a frame. The first zero bit is taken as the third bit of a start delimiter, which fixes the 5-bit code-group boundary. The two code groups that follow are then compared against the full 10-bit start pattern.

A confirmed start opens a packet. Each code group is then turned into a 4-bit nibble, until an end delimiter pair arrives or the line falls back to idle. Code groups outside the data table raise the error output for their slot. Any activity that does not open with the start pattern is reported as a false carrier. A divide-by-five receive clock is brought out with the outputs. Every output changes on its falling edge. An output-enable input floats the nibble, valid and error outputs and leaves carrier sense driven.

Top module: `fe_rx_decode`

## Requirements
- R1: While reset is held and in the first slot after it, `crs`, `rx_dv` and `rx_er` are 0 and `rxd` is 0000.
- R2: A line that carries only ones never raises `crs`. `rx_dv` is never high while `crs` is low.
- R3: The start pattern 11000 10001 is found at any bit offset. It reports two slots with `rxd`=0101 and `rx_dv`=1. The first slot in which `rx_dv` rises always carries 0101.
- R4: Inside a packet, each data code group is reported in its own slot as its nibble, with `rx_dv`=1 and `rx_er`=0. The table maps code to nibble, from 0 to F: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: The end pair 01101 followed by 00111 closes the packet. Its first slot already shows `crs`, `rx_dv` and `rx_er` at 0, with no error flagged.
- R6: Two idle groups (11111 11111) without an end pair close the packet. The first idle slot shows `rx_dv`=1, `rx_er`=1 and `rxd`=0000. The next slot is all zero.
- R7: Inside a packet, a code group that is neither data nor part of a valid delimiter gives one slot with `rx_dv`=1, `rx_er`=1 and `rxd`=0000.
- R8: Activity whose first two groups are not the start pattern is a false carrier. Each of its slots shows `crs`=1, `rx_er`=1, `rx_dv`=0 and `rxd`=1110. This lasts until two consecutive idle groups, whose first slot is all zero.
- R9: `rx_clk` runs at one fifth of `clk`. Outputs change only on its falling edge and hold while it is high.
- R10: With `rx_en` low, `rxd`, `rx_dv` and `rx_er` are high impedance. `crs` still follows the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Descrambled, NRZI-decoded line bit |
| rx_en | input | 1 | Output enable for rxd, rx_dv, rx_er |
| rx_clk | output | 1 | Divide-by-five receive clock |
| rxd | output | 4 | Received nibble (tri-state) |
| rx_dv | output | 1 | Packet data valid (tri-state) |
| rx_er | output | 1 | Receive error (tri-state) |
| crs | output | 1 | Carrier sense, always driven |

## Verification
The bench places start delimiters at random bit offsets after runs of idle. If the design framed groups from a fixed phase, it would decode every packet as garbage. Packets end by random choice either with the end pair or by bare idle. Invalid groups are dropped into the data, including in the last slot before either ending. This catches a design that leaks the error flag into the next slot, misses the one-slot error on an idle ending, or lets carrier sense trail the end pair. False carriers whose first group looks close to a start delimiter check that a near match never raises valid. A packet received with the outputs disabled shows whether data leaks through the floated pins while carrier sense stays live.

// File: rtl/fe_rx_decode.sv
module fe_rx_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_en,
  output logic       rx_clk,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       crs
);
  localparam int GW = 5;
  localparam int NW = 4;
  localparam int OW = NW + 3;
  localparam logic [GW-1:0] C_I = 5'b11111;
  localparam logic [GW-1:0] C_T = 5'b01101;
  localparam logic [GW-1:0] C_R = 5'b00111;
  localparam logic [2*GW-1:0] C_JK = 10'b1100010001;
  localparam logic [OW-1:0] O_NONE  = '0;
  localparam logic [OW-1:0] O_PRE   = 7'b110_0101;
  localparam logic [OW-1:0] O_BAD   = 7'b111_0000;
  localparam logic [OW-1:0] O_FALSE = 7'b101_1110;

  typedef enum logic [2:0] {S_IDLE, S_ACQ0, S_ACQ1, S_KSLOT, S_PKT, S_DROP, S_FALSE} st_t;

  st_t             st;
  logic [2:0]      pos;
  logic [GW-2:0]   sh;
  logic [GW-1:0]   prv;
  logic [OW-1:0]   outv;
  logic            dvalid;
  logic [NW-1:0]   dnib;

  wire [GW-1:0] cur  = {sh, rx_bit};
  wire          done = (pos == 3'd4);

  always_comb begin
    dvalid = 1'b1;
    case (prv)
      5'b11110: dnib = 4'h0;  5'b01001: dnib = 4'h1;
      5'b10100: dnib = 4'h2;  5'b10101: dnib = 4'h3;
      5'b01010: dnib = 4'h4;  5'b01011: dnib = 4'h5;
      5'b01110: dnib = 4'h6;  5'b01111: dnib = 4'h7;
      5'b10010: dnib = 4'h8;  5'b10011: dnib = 4'h9;
      5'b10110: dnib = 4'hA;  5'b10111: dnib = 4'hB;
      5'b11010: dnib = 4'hC;  5'b11011: dnib = 4'hD;
      5'b11100: dnib = 4'hE;  5'b11101: dnib = 4'hF;
      default: begin dnib = 4'h0; dvalid = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pos  <= '0;
      sh   <= '1;
      prv  <= C_I;
      outv <= O_NONE;
    end else begin
      sh  <= {sh[GW-3:0], rx_bit};
      pos <= done ? 3'd0 : pos + 3'd1;
      if (done) prv <= cur;
      case (st)
        S_IDLE:  if (!rx_bit) begin pos <= 3'd3; st <= S_ACQ0; end
        S_ACQ0:  if (done) st <= S_ACQ1;
        S_ACQ1:  if (done) begin
                   if ({prv, cur} == C_JK) begin outv <= O_PRE; st <= S_KSLOT; end
                   else begin outv <= O_FALSE; st <= S_FALSE; end
                 end
        S_KSLOT: if (done) begin outv <= O_PRE; st <= S_PKT; end
        S_PKT:   if (done) begin
                   if (prv == C_T && cur == C_R) begin outv <= O_NONE; st <= S_IDLE; end
                   else if (prv == C_I && cur == C_I) begin outv <= O_BAD; st <= S_DROP; end
                   else if (dvalid) outv <= {3'b110, dnib};
                   else outv <= O_BAD;
                 end
        S_DROP:  if (done) begin outv <= O_NONE; st <= S_IDLE; end
        S_FALSE: if (done) begin
                   if (prv == C_I && cur == C_I) begin outv <= O_NONE; st <= S_IDLE; end
                   else outv <= O_FALSE;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rx_clk = (pos >= 3'd2);
  assign crs    = outv[6];
  assign rx_dv  = rx_en ? outv[5] : 1'bz;
  assign rx_er  = rx_en ? outv[4] : 1'bz;
  assign rxd    = rx_en ? outv[3:0] : 4'bzzzz;

  p_slot_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != 3'd0) |-> $stable(outv));
  p_dv_has_crs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outv[5] |-> outv[6]);
  p_preamble_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outv[5]) |-> (outv[3:0] == 4'b0101));
  p_false_no_dv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FALSE) |-> (!outv[5] && outv[6]));
endmodule

// File: tb/fe_rx_decode_tb.sv
module fe_rx_decode_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1;
  logic rx_en = 1'b1;
  wire        rx_clk;
  wire [3:0]  rxd;
  wire        rx_dv;
  wire        rx_er;
  wire        crs;

  int total = 0;
  int bad = 0;
  int r9_bad = 0;
  int r10_crs = 0;
  int r10_leak = 0;
  logic [6:0] got[$];
  logic [6:0] exp_q[$];
  logic [6:0] prev_v = '0;
  logic       prev_en = 1'b0;

  localparam logic [4:0] G_J = 5'b11000, G_K = 5'b10001, G_T = 5'b01101;
  localparam logic [4:0] G_R = 5'b00111, G_I = 5'b11111, G_H = 5'b00100;
  localparam logic [6:0] E_PRE = 7'b110_0101, E_BAD = 7'b111_0000, E_FALSE = 7'b101_1110;

  fe_rx_decode u_dut (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en),
    .rx_clk(rx_clk), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs));

  always #2 clk = ~clk;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  always @(posedge rx_clk) begin
    #1;
    if (rx_en) begin
      if (crs || rx_dv || rx_er || rxd != 4'h0) got.push_back({crs, rx_dv, rx_er, rxd});
    end else begin
      if (crs === 1'b1) r10_crs++;
      if (rx_dv === 1'b1 || rxd === 4'b1010) r10_leak++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_clk && rx_en && prev_en && ({crs, rx_dv, rx_er, rxd} !== prev_v)) r9_bad++;
    prev_v  <= {crs, rx_dv, rx_er, rxd};
    prev_en <= rx_en;
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
  endtask

  task automatic send_grp(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
    end
  endtask

  task automatic compare(input string tag);
    int mism = -1;
    if (got.size() == exp_q.size())
      for (int i = 0; i < got.size(); i++)
        if (mism < 0 && got[i] !== exp_q[i]) mism = i;
    if (got.size() != exp_q.size())
      check(1'b0, {tag, " slot count"}, got.size(), exp_q.size());
    else if (mism >= 0)
      check(1'b0, $sformatf("%s slot %0d", tag, mism), int'(got[mism]), int'(exp_q[mism]));
    else
      check(1'b1, tag, 0, 0);
    got.delete();
    exp_q.delete();
  endtask

  task automatic run_pkt(input int nd, input bit tr_end, input int bad_at);
    repeat ($urandom_range(0, 9)) send_bit(1'b1);
    send_grp(G_J); send_grp(G_K);
    exp_q.push_back(E_PRE); exp_q.push_back(E_PRE);
    for (int i = 0; i < nd; i++) begin
      if (i == bad_at) begin
        send_grp(G_H); exp_q.push_back(E_BAD);
      end else begin
        logic [3:0] n;
        n = 4'($urandom_range(0, 15));
        send_grp(enc(n)); exp_q.push_back({3'b110, n});
      end
    end
    if (tr_end) begin send_grp(G_T); send_grp(G_R); end
    else begin send_grp(G_I); send_grp(G_I); exp_q.push_back(E_BAD); end
    repeat (20) send_bit(1'b1);
    compare($sformatf("R3 R4 %s%s", tr_end ? "R5" : "R6", bad_at >= 0 ? " R7" : ""));
  endtask

  task automatic run_false(input int ng, input logic [4:0] first);
    repeat ($urandom_range(0, 9)) send_bit(1'b1);
    send_grp(first); exp_q.push_back(E_FALSE);
    for (int i = 1; i < ng; i++) begin
      logic [4:0] g;
      g = 5'($urandom_range(0, 30));
      send_grp(g); exp_q.push_back(E_FALSE);
    end
    repeat (20) send_bit(1'b1);
    compare("R8 false carrier");
  endtask

  initial begin
    void'($urandom(32'd1977));
    repeat (4) @(negedge clk);
    check({crs, rx_dv, rx_er, rxd} === 7'b0, "R1 during reset", int'({crs, rx_dv, rx_er, rxd}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check({crs, rx_dv, rx_er, rxd} === 7'b0, "R1 after reset", int'({crs, rx_dv, rx_er, rxd}), 0);

    repeat (200) send_bit(1'b1);
    compare("R2 idle line");

    run_pkt(0, 1'b1, -1);
    run_pkt(3, 1'b0, -1);
    run_pkt(4, 1'b1, 3);
    run_pkt(4, 1'b0, 3);
    run_pkt(5, 1'b1, 0);
    for (int k = 0; k < 20; k++) begin
      int nd;
      nd = $urandom_range(1, 12);
      run_pkt(nd, 1'($urandom_range(0, 1)),
              ($urandom_range(0, 2) == 0) ? $urandom_range(0, nd - 1) : -1);
    end

    run_false(1, 5'b11001);
    run_false(3, 5'b11010);
    run_false(2, G_J);
    for (int k = 0; k < 3; k++) run_false($urandom_range(1, 6), 5'b11011);

    rx_en = 1'b0;
    send_grp(G_J); send_grp(G_K);
    for (int i = 0; i < 6; i++) send_grp(enc(4'hA));
    send_grp(G_T); send_grp(G_R);
    repeat (20) send_bit(1'b1);
    rx_en = 1'b1;
    repeat (10) send_bit(1'b1);
    check(r10_crs > 0, "R10 crs driven while disabled", r10_crs, 1);
    check(r10_leak == 0, "R10 outputs floated", r10_leak, 0);
    compare("R10 nothing captured while disabled");

    check(r9_bad == 0, "R9 outputs held while rx_clk high", r9_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule